// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives one clock output that is derived from one of four candidate source clocks (slow, main, PLL A, PLL B). The output is that source divided by a power of two. A single configuration word sets both the source and the division exponent. A write-one enable register and a write-one disable register turn the output on and off. After each enable, a ready flag reports that the output is stable. Software reads that flag, or waits on an interrupt line that is masked by its own set/clear pair.

The block runs on one system clock. Each candidate source is brought in through a two-stage synchronizer and tracked by its edges. The output is therefore a register in the system domain, and every source must toggle more slowly than half the system clock rate. The source and exponent can only change while the output is fully stopped. Stopping waits for a low phase, so the output never shows a runt pulse.

Top module: `pckgen_top`

## Requirements
- R1: After reset the output is disabled and `pck_out` is low. `ready` and `irq` are 0, the interrupt mask is 0, and the configuration reads 0 (slow clock, exponent 0).
- R2: Address 0 holds the configuration: bits [1:0] select the source (0 slow, 1 main, 2 PLL A, 3 PLL B) and bits [4:2] hold the exponent. One write sets both fields, and a read returns them in the same positions.
- R3: While running, `pck_out` has a period of 2^e periods of the selected source, with equal high and low time. Exponents 0 to 6 divide by 1 to 64, and exponent 7 divides by 64.
- R4: A configuration write is ignored while the output is enabled or still finishing its last high phase. The value read back stays unchanged.
- R5: Writing 1 to bit 0 of address 1 enables the output. `pck_out` starts low and then toggles on every 2^e-th edge (rising or falling) of the selected source.
- R6: After an enable, `ready` (also bit 0 of address 3) rises in the same cycle as the second falling edge of `pck_out`. `ready` is never 1 while the output is disabled.
- R7: Writing 1 to bit 0 of address 2 disables the output. `ready` is 0 in the next cycle. `pck_out` stops only in a low phase and then stays low.
- R8: `irq` equals `ready` AND the mask bit. Writing 1 to bit 0 of address 4 sets the mask, writing 1 to bit 0 of address 5 clears it, and bit 0 of address 6 reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| src_clk | input | 4 | Candidate source clocks: slow, main, PLL A, PLL B |
| pck_out | output | 1 | Divided clock output |
| ready | output | 1 | Output stable flag |
| irq | output | 1 | Masked ready interrupt |

## Verification
Register writes take effect at the clock edge that samples them. `rdata`, `irq` and the flags are visible half a cycle later. A source edge reaches the divider three edges after it happens: two synchronizer stages and one edge-detect register. The first output toggle is counted from the second edge after the enable write, because the divider starts one edge after the enable register is set. The bench model follows these same latencies and is compared against the design at every falling clock edge. All inputs change one time unit after a rising edge, so sampling never races the design. Directed checks wait for the event they need (ready rising, output falling, a full output period) rather than for a fixed delay.

// File: rtl/pckgen_pkg.sv
package pckgen_pkg;
    localparam int NSRC    = 4;
    localparam int SEL_W   = $clog2(NSRC);
    localparam int EXP_W   = 3;
    localparam int EXP_MAX = 6;
    localparam int CNT_W   = EXP_MAX;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_SLOW = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLLA = 2'd2,
        SRC_PLLB = 2'd3
    } src_e;

    typedef struct packed {
        logic [EXP_W-1:0] pexp;
        src_e             src;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [ADDR_W-1:0] {
        A_CFG   = 3'd0,
        A_ON    = 3'd1,
        A_OFF   = 3'd2,
        A_STAT  = 3'd3,
        A_IEN   = 3'd4,
        A_IDIS  = 3'd5,
        A_IMASK = 3'd6,
        A_RSVD  = 3'd7
    } addr_e;

    // Number of source edges per output half period, minus one.
    function automatic logic [CNT_W-1:0] half_limit(input logic [EXP_W-1:0] e);
        logic [EXP_W-1:0] ec;
        logic [CNT_W:0]   full;
        ec   = (e > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : e;
        full = (CNT_W+1)'(1) << ec;
        return CNT_W'(full - (CNT_W+1)'(1));
    endfunction
endpackage

// File: rtl/pckgen_src_sync.sv
module pckgen_src_sync
    import pckgen_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  src_in,
    input  logic [SW-1:0] sel,
    output logic          edge_o
);
    logic [N-1:0] st2;
    logic         prev_q;
    logic         lvl;

    for (genvar i = 0; i < N; i++) begin : g_sync
        logic s1_q, s2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= src_in[i];
                s2_q <= s1_q;
            end
        end
        assign st2[i] = s2_q;
    end

    assign lvl    = st2[sel];
    assign edge_o = lvl ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end
endmodule

// File: rtl/pckgen_div.sv
module pckgen_div
    import pckgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             edge_i,
    input  logic [EXP_W-1:0] pexp,
    output logic             div_o,
    output logic             run_o,
    output logic             fall_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             wrap;

    assign lim    = half_limit(pexp);
    assign wrap   = edge_i && (cnt_q == lim);
    assign fall_o = run_o && wrap && div_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_o <= 1'b0;
            div_o <= 1'b0;
            cnt_q <= '0;
        end else if (!run_o) begin
            if (en) begin
                run_o <= 1'b1;
                div_o <= 1'b0;
                cnt_q <= '0;
            end
        end else if (!en && !div_o) begin
            run_o <= 1'b0;
            cnt_q <= '0;
        end else if (edge_i) begin
            if (wrap) begin
                cnt_q <= '0;
                div_o <= ~div_o;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !run_o |-> !div_o); // R7
    AST_DIV_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (div_o != $past(div_o)) |-> $past(edge_i)); // R3
endmodule

// File: rtl/pckgen_regs.sv
module pckgen_regs
    import pckgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              run,
    input  logic              fall,
    output cfg_t              cfg_o,
    output logic              en_o,
    output logic              ready_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] rdata
);
    logic       mask_q;
    logic [1:0] falls_q;
    logic       on_w, off_w, cfg_w;
    logic       unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:CFG_W];
    assign on_w  = wr_en && (addr == A_ON)  && wdata[0] && !en_o;
    assign off_w = wr_en && (addr == A_OFF) && wdata[0];
    assign cfg_w = wr_en && (addr == A_CFG) && !en_o && !run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o   <= '{pexp: '0, src: SRC_SLOW};
            en_o    <= 1'b0;
            ready_o <= 1'b0;
            falls_q <= '0;
            mask_q  <= 1'b0;
        end else begin
            if (cfg_w) cfg_o <= cfg_t'(wdata[CFG_W-1:0]);
            if (off_w) begin
                en_o    <= 1'b0;
                ready_o <= 1'b0;
                falls_q <= '0;
            end else if (on_w) begin
                en_o    <= 1'b1;
                ready_o <= 1'b0;
                falls_q <= '0;
            end else if (en_o && fall && !ready_o) begin
                falls_q <= falls_q + 1'b1;
                if (falls_q == 2'd1) ready_o <= 1'b1;
            end
            if (wr_en && addr == A_IEN && wdata[0])       mask_q <= 1'b1;
            else if (wr_en && addr == A_IDIS && wdata[0]) mask_q <= 1'b0;
        end
    end

    assign irq_o = ready_o & mask_q;

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:   rdata[CFG_W-1:0] = cfg_o;
            A_STAT:  rdata[0] = ready_o;
            A_IMASK: rdata[0] = mask_q;
            default: rdata = '0;
        endcase
    end

    AST_READY_CLR_ON_OFF: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_OFF && wdata[0]) |=> !ready_o); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (en_o || run) |=> $stable(cfg_o)); // R4
    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !en_o |-> !ready_o); // R6
endmodule

// File: rtl/pckgen_top.sv
module pckgen_top
    import pckgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NSRC-1:0]   src_clk,
    output logic              pck_out,
    output logic              ready,
    output logic              irq
);
    cfg_t cfg;
    logic en, run, fall, src_edge;

    pckgen_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .run(run), .fall(fall), .cfg_o(cfg), .en_o(en),
        .ready_o(ready), .irq_o(irq), .rdata(rdata)
    );

    pckgen_src_sync #(.N(NSRC), .SW(SEL_W)) u_sync (
        .clk(clk), .rst(rst), .src_in(src_clk), .sel(cfg.src), .edge_o(src_edge)
    );

    pckgen_div u_div (
        .clk(clk), .rst(rst), .en(en), .edge_i(src_edge), .pexp(cfg.pexp),
        .div_o(pck_out), .run_o(run), .fall_o(fall)
    );
endmodule

// File: tb/pckgen_top_bench.sv
`timescale 1ns/1ps
module pckgen_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [3:0]  src_clk = 4'd0;
    logic        pck_out, ready, irq;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pckgen_top u_pckgen_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_clk(src_clk), .pck_out(pck_out), .ready(ready), .irq(irq)
    );

    // source clocks: half periods in system cycles
    int hp [4] = '{7, 3, 2, 5};
    int sc [4] = '{0, 0, 0, 0};
    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (sc[i] >= hp[i] - 1) begin
                sc[i] = 0;
                src_clk[i] <= ~src_clk[i];
            end else begin
                sc[i] = sc[i] + 1;
            end
        end
    end

    // behavioural reference
    logic [3:0] m_s1 = 0, m_s2 = 0;
    bit   m_prev = 0, m_div = 0, m_run = 0, m_en = 0, m_ready = 0, m_mask = 0;
    int   m_src = 0, m_exp = 0, m_cnt = 0, m_falls = 0;

    always @(posedge clk) begin
        bit lvl, ed, fl;
        int per;
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_div <= 0; m_run <= 0;
            m_en <= 0; m_ready <= 0; m_mask <= 0; m_src <= 0; m_exp <= 0;
            m_cnt <= 0; m_falls <= 0;
        end else begin
            lvl = m_s2[m_src];
            ed  = (lvl != m_prev);
            fl  = 0;
            per = 1 << ((m_exp > 6) ? 6 : m_exp);
            m_s1 <= src_clk; m_s2 <= m_s1; m_prev <= lvl;
            if (!m_run) begin
                if (m_en) begin m_run <= 1; m_div <= 0; m_cnt <= 0; end
            end else if (!m_en && !m_div) begin
                m_run <= 0; m_cnt <= 0;
            end else if (ed) begin
                if (m_cnt + 1 == per) begin
                    m_cnt <= 0; m_div <= !m_div; fl = m_div;
                end else m_cnt <= m_cnt + 1;
            end
            if (wr_en && addr == 0 && !m_en && !m_run) begin
                m_src <= wdata[1:0]; m_exp <= wdata[4:2];
            end
            if (wr_en && addr == 2 && wdata[0]) begin
                m_en <= 0; m_ready <= 0; m_falls <= 0;
            end else if (wr_en && addr == 1 && wdata[0] && !m_en) begin
                m_en <= 1; m_ready <= 0; m_falls <= 0;
            end else if (m_en && fl && !m_ready) begin
                m_falls <= m_falls + 1;
                if (m_falls == 1) m_ready <= 1;
            end
            if (wr_en && addr == 4 && wdata[0]) m_mask <= 1;
            else if (wr_en && addr == 5 && wdata[0]) m_mask <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int er;
        if (!done) begin
            case (addr)
                3'd0: er = (m_exp << 2) | m_src;
                3'd3: er = m_ready;
                3'd6: er = m_mask;
                default: er = 0;
            endcase
            chk(pck_out == m_div, "R5 pck_out", pck_out, m_div);
            chk(ready == m_ready, "R6 ready", ready, m_ready);
            chk(irq == (m_ready & m_mask), "R8 irq", irq, m_ready & m_mask);
            chk(rdata == er, "R2 rdata", rdata, er);
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        addr = a[2:0]; wdata = d; wr_en = 1;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input int a, output int v);
        @(posedge clk); #1;
        addr = a[2:0];
        @(negedge clk);
        v = rdata;
    endtask

    task automatic run_case(input int src, input int ex, input bit mask_on);
        int v, falls, highs, t;
        bit pv;
        wr(0, (ex << 2) | src);
        rd(0, v);
        chk(v == ((ex << 2) | src), "R2 cfg readback", v, (ex << 2) | src);
        wr(1, 1);
        falls = 0; t = 0; pv = pck_out;
        while (!ready && t < 5000) begin
            @(negedge clk);
            if (pv && !pck_out) falls++;
            pv = pck_out; t++;
        end
        chk(ready == 1, "R6 ready rises", ready, 1);
        chk(falls == 2, "R6 two output cycles", falls, 2);
        chk(irq == mask_on, "R8 irq vs mask", irq, mask_on);
        wr(0, 32'h3);
        rd(0, v);
        chk(v == ((ex << 2) | src), "R4 cfg frozen", v, (ex << 2) | src);
        repeat (50) @(negedge clk);
        wr(2, 1);
        @(negedge clk);
        chk(ready == 0, "R7 ready clears", ready, 0);
        t = 0;
        while (pck_out && t < 2000) begin @(negedge clk); t++; end
        highs = 0;
        repeat (150) begin @(negedge clk); if (pck_out) highs++; end
        chk(highs == 0, "R7 output held low", highs, 0);
    endtask

    initial begin
        int v, per, t;
        bit pv;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(pck_out == 0 && ready == 0 && irq == 0, "R1 outputs", {pck_out, ready, irq}, 0);
        rd(0, v);
        chk(v == 0, "R1 cfg", v, 0);
        rd(6, v);
        chk(v == 0, "R1 mask", v, 0);

        wr(4, 1);
        rd(6, v);
        chk(v == 1, "R8 mask set", v, 1);
        run_case(1, 5, 1);
        run_case(0, 0, 1);
        run_case(2, 1, 1);
        run_case(3, 7, 1);
        wr(5, 1);
        rd(6, v);
        chk(v == 0, "R8 mask clear", v, 0);
        run_case(2, 6, 0);

        // R3: exponent 7 on a 4-cycle source gives a 256-cycle period
        wr(0, (7 << 2) | 2);
        wr(1, 1);
        t = 0;
        while (!ready && t < 5000) begin @(negedge clk); t++; end
        pv = pck_out; t = 0;
        while (!(pck_out && !pv) && t < 1000) begin pv = pck_out; @(negedge clk); t++; end
        per = 0; pv = pck_out;
        do begin pv = pck_out; @(negedge clk); per++; end
        while (!(pck_out && !pv) && per < 1000);
        chk(per == 256, "R3 divide by 64", per, 256);
        wr(2, 1);
        repeat (400) @(negedge clk);

        // R3 divide by one on the main source: period 6 cycles
        wr(0, 1);
        wr(1, 1);
        repeat (40) @(negedge clk);
        pv = pck_out; t = 0;
        while (!(pck_out && !pv) && t < 100) begin pv = pck_out; @(negedge clk); t++; end
        per = 0;
        do begin pv = pck_out; @(negedge clk); per++; end
        while (!(pck_out && !pv) && per < 100);
        chk(per == 6, "R3 divide by 1", per, 6);
        wr(2, 1);
        repeat (20) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule